// File: doc/BRIEF.md
# Pending-Store Queue with Load Forwarding

This block sits between a CPU core and its private data cache. A store whose cache line is not held in a writable state does not stall the core. The block raises a read-for-ownership request for that line and parks the store in a small circular queue. Each queued store carries its word address, its data and its byte enables. An entry becomes eligible to leave once its line is writable, either because the cache already owned the line when the store arrived or because a fill for that line has since come back. Only the oldest entry may write to the cache, so stores reach the cache strictly in program order. Stores still in the queue cannot be seen by any other agent until they reach the cache.

Loads from the same core search the queue before they use the cache. If the youngest queued store that touches any requested byte covers every requested byte, its data is returned directly. If it covers only some of them, the load is told to stall until that store has drained. If no queued store touches the requested bytes, the load is left to the cache. A one-cycle barrier pulse closes the store port until the queue is completely empty.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, and `wr_valid`, `ld_hit` and `ld_stall` are 0.
- R2: In the cycle a store is accepted (`st_valid` and `st_ready` both 1) with `st_line_ok` at 0, `rfo_valid` is 1 and `rfo_line` equals the store address shifted right by `LINE_LG2` bits. With `st_line_ok` at 1, `rfo_valid` stays 0.
- R3: A queued store is offered on the cache write port only after its line is writable. This holds if `st_line_ok` was 1 when the store was accepted, or if a later `fill_valid` arrived with `fill_line` equal to the store's line.
- R4: Queued stores leave on the write port in the order they were accepted. A younger store whose line is ready still waits behind an older store whose line is not.
- R5: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr`, `wr_data` and `wr_be` keep their values into the next cycle.
- R6: For a load (`ld_valid` = 1), take the youngest queued store at the same word address whose byte enables share at least one bit with `ld_be`. If that store's enables include every bit of `ld_be`, then `ld_hit` is 1 and `ld_data` holds that store's data. Byte i is bits 8i+7..8i, enabled by bit i of `ld_be`.
- R7: If that youngest overlapping store lacks any byte requested by the load, then `ld_stall` is 1 and `ld_hit` is 0.
- R8: When no queued store at the load's address shares an enabled byte with it, `ld_hit` and `ld_stall` are both 0.
- R9: With `DEPTH` stores queued, `st_ready` is 0.
- R10: A `bar_valid` pulse while the queue is not empty drives `st_ready` to 0 from the next cycle on. It stays 0 until the queue has fully drained.
- R11: A store accepted in the same cycle as a fill for its own line counts as ready and drains without any further fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered by the core |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_line_ok | input | 1 | Cache already holds the store's line writable |
| st_ready | output | 1 | Store port open |
| rfo_valid | output | 1 | Read-for-ownership request pulse |
| rfo_line | output | AW-LINE_LG2 | Line requested |
| fill_valid | input | 1 | A requested line has arrived writable |
| fill_line | input | AW-LINE_LG2 | Line that arrived |
| ld_valid | input | 1 | Load lookup |
| ld_addr | input | AW | Load word address |
| ld_be | input | DW/8 | Bytes requested by the load |
| ld_hit | output | 1 | Load fully served from the queue |
| ld_data | output | DW | Forwarded data |
| ld_stall | output | 1 | Partial overlap, load must wait |
| bar_valid | input | 1 | Store barrier pulse |
| wr_valid | output | 1 | Oldest store offered to the cache |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_be | output | DW/8 | Write byte enables |
| wr_ready | input | 1 | Cache takes the write |

## Verification
Two pairs of events are made to fall in the same cycle. In the first, a fill for a line arrives in the cycle a store to that same line is accepted. With `wr_ready` high throughout, the store must reach the write port without a second fill. In the second, the core stores into the last free slot while the write port is held off. This checks that the port closes immediately and that the four parked stores then leave in acceptance order once a single fill releases the oldest. Both are judged by a scoreboard that records each accepted store and compares it against every write handshake.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    FWD_NONE  = 2'd0,
    FWD_HIT   = 2'd1,
    FWD_STALL = 2'd2
  } fwd_kind_e;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl #(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             bar_valid,
  output logic [PTR_W-1:0] head_ptr,
  output logic [PTR_W-1:0] tail_ptr,
  output logic             full,
  output logic             empty,
  output logic             bar_block
);
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bar_pend_q, bar_pend_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (push) tail_d = tail_q + 1'b1;
    if (pop)  head_d = head_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
    bar_pend_d = (bar_pend_q || bar_valid) && (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q     <= '0;
      tail_q     <= '0;
      cnt_q      <= '0;
      bar_pend_q <= 1'b0;
    end else begin
      head_q     <= head_d;
      tail_q     <= tail_d;
      cnt_q      <= cnt_d;
      bar_pend_q <= bar_pend_d;
    end
  end

  assign head_ptr  = head_q;
  assign tail_ptr  = tail_q;
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign bar_block = bar_pend_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(DEPTH)));  // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));  // R4
  AST_BARRIER_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bar_pend_q) |-> (cnt_q == '0));  // R10
endmodule

// File: rtl/sq_entries.sv
module sq_entries #(
  parameter int DEPTH    = 4,
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int LINE_LG2 = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int BW    = DW / 8,
  localparam int LW    = AW - LINE_LG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [PTR_W-1:0] tail_ptr,
  input  logic [AW-1:0]    st_addr,
  input  logic [DW-1:0]    st_data,
  input  logic [BW-1:0]    st_be,
  input  logic             st_line_ok,
  input  logic             fill_valid,
  input  logic [LW-1:0]    fill_line,
  input  logic             pop,
  input  logic [PTR_W-1:0] head_ptr,
  output logic [AW-1:0]    ent_addr [DEPTH],
  output logic [DW-1:0]    ent_data [DEPTH],
  output logic [BW-1:0]    ent_be   [DEPTH],
  output logic             ent_vld  [DEPTH],
  output logic             ent_rdy  [DEPTH]
);
  logic st_fill_hit;
  assign st_fill_hit = fill_valid && (fill_line == st_addr[AW-1:LINE_LG2]);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic          wr_en, pop_en, fill_en;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [BW-1:0] be_q;
    logic          vld_q, vld_d, rdy_q, rdy_d;

    assign wr_en   = push && (tail_ptr == PTR_W'(g));
    assign pop_en  = pop && (head_ptr == PTR_W'(g));
    assign fill_en = fill_valid && vld_q && (addr_q[AW-1:LINE_LG2] == fill_line);

    always_comb begin
      vld_d = vld_q;
      rdy_d = rdy_q;
      if (pop_en) begin
        vld_d = 1'b0;
        rdy_d = 1'b0;
      end
      if (fill_en) rdy_d = 1'b1;
      if (wr_en) begin
        vld_d = 1'b1;
        rdy_d = st_line_ok || st_fill_hit;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        rdy_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
        rdy_q <= rdy_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        data_q <= '0;
        be_q   <= '0;
      end else if (wr_en) begin
        addr_q <= st_addr;
        data_q <= st_data;
        be_q   <= st_be;
      end
    end

    assign ent_addr[g] = addr_q;
    assign ent_data[g] = data_q;
    assign ent_be[g]   = be_q;
    assign ent_vld[g]  = vld_q;
    assign ent_rdy[g]  = rdy_q;

    AST_LEAVE_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
      pop_en |-> (vld_q && rdy_q));  // R3
  end
endmodule

// File: rtl/sq_fwd.sv
module sq_fwd
  import sq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int BW    = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] head_ptr,
  input  logic [AW-1:0]    ent_addr [DEPTH],
  input  logic [DW-1:0]    ent_data [DEPTH],
  input  logic [BW-1:0]    ent_be   [DEPTH],
  input  logic             ent_vld  [DEPTH],
  input  logic             ld_valid,
  input  logic [AW-1:0]    ld_addr,
  input  logic [BW-1:0]    ld_be,
  output fwd_kind_e        kind,
  output logic [DW-1:0]    fwd_data
);
  logic          found;
  logic [BW-1:0] sel_be;
  logic [DW-1:0] sel_data;

  // Walk from oldest to youngest; later matches overwrite earlier ones.
  always_comb begin
    found    = 1'b0;
    sel_be   = '0;
    sel_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PTR_W-1:0] idx;
      idx = head_ptr + PTR_W'(i);
      if (ent_vld[idx] && (ent_addr[idx] == ld_addr) && ((ent_be[idx] & ld_be) != '0)) begin
        found    = 1'b1;
        sel_be   = ent_be[idx];
        sel_data = ent_data[idx];
      end
    end
  end

  always_comb begin
    kind     = FWD_NONE;
    fwd_data = '0;
    if (ld_valid && found) begin
      if ((sel_be & ld_be) == ld_be) begin
        kind     = FWD_HIT;
        fwd_data = sel_data;
      end else begin
        kind = FWD_STALL;
      end
    end
  end

  AST_IDLE_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> (kind == FWD_NONE));  // R8
endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int LINE_LG2 = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int BW    = DW / 8,
  localparam int LW    = AW - LINE_LG2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [BW-1:0] st_be,
  input  logic          st_line_ok,
  output logic          st_ready,
  output logic          rfo_valid,
  output logic [LW-1:0] rfo_line,
  input  logic          fill_valid,
  input  logic [LW-1:0] fill_line,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [BW-1:0] ld_be,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          ld_stall,
  input  logic          bar_valid,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [BW-1:0] wr_be,
  input  logic          wr_ready
);
  logic [PTR_W-1:0] head_ptr, tail_ptr;
  logic             full, empty, bar_block, push, pop;
  logic [AW-1:0]    ent_addr [DEPTH];
  logic [DW-1:0]    ent_data [DEPTH];
  logic [BW-1:0]    ent_be   [DEPTH];
  logic             ent_vld  [DEPTH];
  logic             ent_rdy  [DEPTH];
  fwd_kind_e        kind;

  assign st_ready  = !full && !bar_block;
  assign push      = st_valid && st_ready;
  assign rfo_valid = push && !st_line_ok;
  assign rfo_line  = st_addr[AW-1:LINE_LG2];

  assign wr_valid = ent_vld[head_ptr] && ent_rdy[head_ptr];
  assign wr_addr  = ent_addr[head_ptr];
  assign wr_data  = ent_data[head_ptr];
  assign wr_be    = ent_be[head_ptr];
  assign pop      = wr_valid && wr_ready;

  sq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rst_n, .push, .pop, .bar_valid,
    .head_ptr, .tail_ptr, .full, .empty, .bar_block
  );

  sq_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .LINE_LG2(LINE_LG2)) u_ent (
    .clk, .rst_n, .push, .tail_ptr, .st_addr, .st_data, .st_be, .st_line_ok,
    .fill_valid, .fill_line, .pop, .head_ptr,
    .ent_addr, .ent_data, .ent_be, .ent_vld, .ent_rdy
  );

  sq_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .clk, .rst_n, .head_ptr, .ent_addr, .ent_data, .ent_be, .ent_vld,
    .ld_valid, .ld_addr, .ld_be, .kind, .fwd_data(ld_data)
  );

  assign ld_hit   = (kind == FWD_HIT);
  assign ld_stall = (kind == FWD_STALL);

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));  // R5
  AST_HIT_XOR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_stall));  // R7
  AST_EMPTY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !$past(bar_valid)) |-> st_ready);  // R10
endmodule

// File: tb/store_queue_tb.sv
`timescale 1ns/1ps
module store_queue_tb_top;
  localparam int AW = 16, DW = 32, BW = 4, LG = 2, LW = AW - LG;

  logic clk = 1'b0;
  logic rst_n;
  logic st_valid, st_line_ok, st_ready, rfo_valid, fill_valid, ld_valid;
  logic ld_hit, ld_stall, bar_valid, wr_valid, wr_ready;
  logic [AW-1:0] st_addr, ld_addr, wr_addr;
  logic [DW-1:0] st_data, ld_data, wr_data;
  logic [BW-1:0] st_be, ld_be, wr_be;
  logic [LW-1:0] rfo_line, fill_line;

  int errors = 0;
  int checks = 0;
  int drains = 0;
  logic [AW+DW+BW-1:0] exp_q [$];

  always #2 clk = ~clk;

  store_queue dut_i (
    .clk, .rst_n, .st_valid, .st_addr, .st_data, .st_be, .st_line_ok, .st_ready,
    .rfo_valid, .rfo_line, .fill_valid, .fill_line, .ld_valid, .ld_addr, .ld_be,
    .ld_hit, .ld_data, .ld_stall, .bar_valid, .wr_valid, .wr_addr, .wr_data,
    .wr_be, .wr_ready
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mask(input logic [DW-1:0] d, input logic [BW-1:0] be);
    logic [DW-1:0] r;
    for (int i = 0; i < BW; i++) r[8*i +: 8] = be[i] ? d[8*i +: 8] : 8'h00;
    return r;
  endfunction

  // Driver: presents one store for one cycle, records the expected write.
  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [BW-1:0] be, input logic ok, input logic fill_same);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_line_ok = ok;
    fill_valid = fill_same; fill_line = a[AW-1:LG];
    #1;
    check("R2 rfo_valid", 64'(rfo_valid), 64'(!ok));
    if (!ok) check("R2 rfo_line", 64'(rfo_line), 64'(a[AW-1:LG]));
    if (st_ready) exp_q.push_back({a, d, be});
    @(negedge clk);
    st_valid = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic do_load(input string req, input logic [AW-1:0] a, input logic [BW-1:0] be,
                         input logic hit, input logic stall, input logic [DW-1:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_be = be;
    #1;
    check({req, " hit"}, 64'(ld_hit), 64'(hit));
    check({req, " stall"}, 64'(ld_stall), 64'(stall));
    if (hit) check({req, " data"}, 64'(mask(ld_data, be)), 64'(mask(d, be)));
    ld_valid = 1'b0;
  endtask

  // Monitor: pops expected writes as handshakes complete.
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && wr_valid && wr_ready) begin
        drains++;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 unexpected write: actual=%0h expected=none", wr_addr);
        end else begin
          logic [AW+DW+BW-1:0] e;
          e = exp_q.pop_front();
          check("R4 write order", 64'({wr_addr, wr_data, wr_be}), 64'(e));
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; st_valid = 0; st_addr = 0; st_data = 0; st_be = 0; st_line_ok = 0;
    fill_valid = 0; fill_line = 0; ld_valid = 0; ld_addr = 0; ld_be = 0;
    bar_valid = 0; wr_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 st_ready", 64'(st_ready), 64'd1);
    check("R1 wr_valid", 64'(wr_valid), 64'd0);
    check("R1 ld_hit", 64'(ld_hit), 64'd0);

    // Four stores with the write port held off
    do_store(16'h0010, 32'h1111_1111, 4'hF, 1'b0, 1'b0);
    check("R3 not ready before fill", 64'(wr_valid), 64'd0);
    do_store(16'h0020, 32'h2222_2222, 4'hF, 1'b1, 1'b0);
    check("R4 younger waits", 64'(wr_valid), 64'd0);
    do_load("R6 full match", 16'h0010, 4'hF, 1'b1, 1'b0, 32'h1111_1111);
    do_store(16'h0010, 32'h0000_CCCC, 4'h3, 1'b0, 1'b0);
    do_load("R6 youngest", 16'h0010, 4'h3, 1'b1, 1'b0, 32'h0000_CCCC);
    do_load("R6 older bytes", 16'h0010, 4'hC, 1'b1, 1'b0, 32'h1111_1111);
    do_load("R7 partial", 16'h0010, 4'hF, 1'b0, 1'b1, 32'h0);
    do_load("R8 no match", 16'h0030, 4'hF, 1'b0, 1'b0, 32'h0);
    do_store(16'h0031, 32'h4444_4444, 4'hF, 1'b1, 1'b0);
    #1 check("R9 full blocks", 64'(st_ready), 64'd0);

    // Fill releases the oldest; all drain in order
    @(negedge clk);
    fill_valid = 1'b1; fill_line = 14'h4; wr_ready = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0;
    repeat (8) @(negedge clk);
    check("R4 all drained", 64'(exp_q.size()), 64'd0);
    check("R3 drain count", 64'(drains), 64'd4);

    // Barrier
    wr_ready = 1'b0;
    do_store(16'h0040, 32'h5555_5555, 4'hF, 1'b1, 1'b0);
    @(negedge clk); bar_valid = 1'b1;
    @(negedge clk); bar_valid = 1'b0;
    #1 check("R10 barrier closes", 64'(st_ready), 64'd0);
    repeat (3) @(negedge clk);
    #1 check("R10 barrier holds", 64'(st_ready), 64'd0);
    check("R5 write held", 64'(wr_valid), 64'd1);
    wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R10 reopens", 64'(st_ready), 64'd1);

    // Fill in the same cycle as the store
    do_store(16'h0050, 32'h6666_6666, 4'hF, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    check("R11 same-cycle fill drained", 64'(exp_q.size()), 64'd0);
    check("R11 drain count", 64'(drains), 64'd6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule